// File: doc/BRIEF.md
# Chainable Active-Low Priority Encoder

This block is a purely combinational priority encoder with no clock and no state. Each basic stage looks at eight active-low request lines and an active-low enable. It reports the highest-numbered asserted request as an active-low 3-bit code, which is the bitwise inverse of that request's index. It also drives an active-low "some request present" flag and an active-low enable output. The enable output is asserted only when the stage is enabled and sees no request at all.

Because of the enable output, stages can be chained with no added logic. The enable output of a stage feeds the enable input of the stage just below it in priority. As a result, only the highest stage that holds a request ever reports one.

The top module wraps a parameterized number of stages (1, 2, 4 or 8) into one wider encoder, covering 8 to 64 requests. The upper code bits come from the per-stage request flags, encoded in the same inverted style. The lower three bits are the AND of all the stage codes, which works because every disabled or idle stage drives all ones.

Top module: `prio_chain_enc`

## Requirements
- R1: With the enable low, each stage's 3-bit code equals the bitwise inverse of the index of the highest-numbered low request line. Index 7 gives 000, index 6 gives 001, and index 0 gives 111.
- R2: Request lines numbered below the winning line have no effect on any stage output.
- R3: With the enable high, a stage drives its code, flag and enable output all high, whatever the request lines are.
- R4: With the enable low and every request line high, a stage drives its code to 111, holds its flag high and pulls its enable output low.
- R5: With the enable low and at least one request line low, a stage pulls its flag low and drives its enable output high.
- R6: With the wrapper enabled and some request low, the wrapper code (width 3 + log2 of the stage count) equals the bitwise inverse of the index of the highest low request over the whole vector. Stage s covers bits 8s to 8s+7.
- R7: In the wrapper, at most one stage reports a request. A request in a higher stage hides every request in the lower stages.
- R8: The wrapper's flag and enable output follow R3 to R5 over the whole request vector: both high when disabled, flag low when any request is low, enable output low only when enabled with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_n | input | 1 | Active-low enable for the whole chain |
| req_n | input | 8*N_STAGES | Active-low request lines; the highest index has the highest priority |
| code_n | output | 3+log2(N_STAGES) | Inverted index of the winning request |
| grp_n | output | 1 | Low when enabled and any request is low |
| eo_n | output | 1 | Low when enabled and no request is low; drives a further chain |

## Verification
One standalone stage is swept over all 512 combinations of enable and request lines. That sweep separates the disabled, idle and active cases, and also checks every winner against every pattern of lower lines that must be ignored.

The wrapper gets several kinds of pattern:
- a single low line walked over all positions, which pins each code value and the stage-bit mapping;
- pairs of low lines in the same stage and in different stages, which show whether a higher stage hides a lower one;
- random vectors of varying density, both enabled and disabled.

Expected values come from the bench's own shift-based search for the top set bit.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } win_t;

  // Highest-numbered low line among eight; hit clear when none is low.
  function automatic win_t pick_highest(input logic [LINES-1:0] lines_n);
    win_t w;
    w = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!lines_n[i]) begin
        w.hit = 1'b1;
        w.idx = IDX_W'(i);
      end
    end
    return w;
  endfunction

  // Active-low code style: the inverse of the index.
  function automatic logic [IDX_W-1:0] to_low_code(input logic [IDX_W-1:0] idx);
    return ~idx;
  endfunction
endpackage

// File: rtl/prio_stage.sv
module prio_stage
  import prio_enc_pkg::*;
(
  input  logic             ei_n,
  input  logic [LINES-1:0] req_n,
  output logic [IDX_W-1:0] a_n,
  output logic             gs_n,
  output logic             eo_n
);
  win_t win;
  logic enabled;
  logic req_seen;

  assign win      = pick_highest(req_n);
  assign enabled  = !ei_n;
  assign req_seen = win.hit;

  always_comb begin
    if (!enabled) begin
      a_n  = '1;
      gs_n = 1'b1;
      eo_n = 1'b1;
    end else if (req_seen) begin
      a_n  = to_low_code(win.idx);
      gs_n = 1'b0;
      eo_n = 1'b1;
    end else begin
      a_n  = '1;
      gs_n = 1'b1;
      eo_n = 1'b0;
    end
  end

  always_comb begin
    if (ei_n) begin
      p_disabled_high_r3: assert (a_n == '1 && gs_n && eo_n);
    end
    if (!ei_n) begin
      p_flags_exclusive_r5: assert (gs_n != eo_n);
    end
    if (!ei_n && (&req_n)) begin
      p_idle_r4: assert (a_n == '1 && gs_n && !eo_n);
    end
    if (!gs_n) begin
      p_winner_low_r1: assert (!req_n[~a_n]);
    end
    for (int j = 0; j < LINES; j++) begin
      if (!gs_n && j > int'(IDX_W'(~a_n))) begin
        p_above_idle_r2: assert (req_n[j]);
      end
    end
  end
endmodule

// File: rtl/grp_index_enc.sv
module grp_index_enc #(
  parameter int N_GRP = 4,
  localparam int SW   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic [N_GRP-1:0] gs_n,
  output logic [SW-1:0]    idx_n
);
  logic [SW-1:0] idx;
  logic          any;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int g = 0; g < N_GRP; g++) begin
      if (!gs_n[g]) begin
        idx = SW'(g);
        any = 1'b1;
      end
    end
    idx_n = any ? ~idx : '1;
  end

  always_comb begin
    if (&gs_n) begin
      p_idle_ones_r8: assert (idx_n == '1);
    end
  end
endmodule

// File: rtl/prio_chain_enc.sv
module prio_chain_enc
  import prio_enc_pkg::*;
#(
  parameter int N_STAGES = 4,
  localparam int REQ_W   = LINES * N_STAGES,
  localparam int STAGE_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 0,
  localparam int CODE_W  = IDX_W + STAGE_W
) (
  input  logic              en_n,
  input  logic [REQ_W-1:0]  req_n,
  output logic [CODE_W-1:0] code_n,
  output logic              grp_n,
  output logic              eo_n
);
  logic [N_STAGES:0]               ei_chain;
  logic [N_STAGES-1:0]             gs_vec;
  logic [N_STAGES-1:0][IDX_W-1:0]  stage_code;
  logic [IDX_W-1:0]                low_bits;

  assign ei_chain[N_STAGES] = en_n;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    prio_stage u_stage (
      .ei_n  (ei_chain[s+1]),
      .req_n (req_n[LINES*s +: LINES]),
      .a_n   (stage_code[s]),
      .gs_n  (gs_vec[s]),
      .eo_n  (ei_chain[s])
    );
  end

  always_comb begin
    low_bits = '1;
    for (int s = 0; s < N_STAGES; s++) low_bits = low_bits & stage_code[s];
  end

  if (N_STAGES > 1) begin : g_upper
    logic [STAGE_W-1:0] upper_n;
    grp_index_enc #(.N_GRP(N_STAGES)) u_grp (
      .gs_n  (gs_vec),
      .idx_n (upper_n)
    );
    assign code_n = {upper_n, low_bits};
  end else begin : g_single
    assign code_n = low_bits;
  end

  assign grp_n = &gs_vec;
  assign eo_n  = ei_chain[0];

  always_comb begin
    p_one_stage_r7: assert ($countones(~gs_vec) <= 1);
    if (!eo_n) begin
      p_eo_idle_r8: assert (!en_n && (&req_n));
    end
    if (en_n) begin
      p_off_high_r8: assert (code_n == '1 && grp_n && eo_n);
    end
    if (!grp_n) begin
      p_winner_low_r6: assert (!req_n[~code_n]);
    end
  end
endmodule

// File: tb/prio_chain_enc_tb_top.sv
module prio_chain_enc_tb_top;
  localparam int NS = 4;
  localparam int RW = 8 * NS;
  localparam int CW = 3 + $clog2(NS);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic          en_n  = 1'b1;
  logic [RW-1:0] req_n = '1;
  logic [CW-1:0] code_n;
  logic          grp_n, eo_n;

  logic          s_ei_n  = 1'b1;
  logic [7:0]    s_req_n = '1;
  logic [2:0]    s_a_n;
  logic          s_gs_n, s_eo_n;

  prio_chain_enc #(.N_STAGES(NS)) dut_i (
    .en_n(en_n), .req_n(req_n), .code_n(code_n), .grp_n(grp_n), .eo_n(eo_n)
  );

  prio_stage stg_i (
    .ei_n(s_ei_n), .req_n(s_req_n), .a_n(s_a_n), .gs_n(s_gs_n), .eo_n(s_eo_n)
  );

  // Top set bit by repeated halving.
  function automatic int top_bit(input logic [63:0] v);
    int k;
    k = 0;
    while (v > 64'd1) begin
      v = v >> 1;
      k++;
    end
    return k;
  endfunction

  // Returns {code, flag, enable-out} for a width of w lines, code width cw.
  function automatic logic [15:0] model(input logic e_n, input logic [63:0] r_n,
                                        input int w, input int cw);
    logic [63:0] act;
    logic [15:0] allones;
    act = ~r_n & ((64'd1 << w) - 64'd1);
    allones = (16'd1 << cw) - 16'd1;
    if (e_n) return {allones, 2'b11};
    if (act == 64'd0) return {allones, 2'b10};
    return {(allones - 16'(top_bit(act))), 2'b01};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (en_n=%b req_n=%h)", req, got, exp, en_n, req_n);
    end
  endtask

  task automatic apply_top(input logic e, input logic [RW-1:0] r, input string req);
    @(posedge clk);
    en_n  = e;
    req_n = r;
    @(negedge clk);
    check(req, 16'({code_n, grp_n, eo_n}), model(e, 64'(r), RW, CW));
  endtask

  initial begin
    @(negedge clk);
    check("R3 R8 reset idle", 16'({code_n, grp_n, eo_n}), 16'((1 << (CW + 2)) - 1));

    // Exhaustive single stage: R1 R2 R3 R4 R5.
    for (int e = 0; e < 2; e++) begin
      for (int v = 0; v < 256; v++) begin
        @(posedge clk);
        s_ei_n  = 1'(e);
        s_req_n = 8'(v);
        @(negedge clk);
        check((e == 1) ? "R3 stage disabled" : ((v == 255) ? "R4 stage idle" : "R1 R2 R5 stage"),
              16'({s_a_n, s_gs_n, s_eo_n}), model(1'(e), 64'(v), 8, 3));
      end
    end

    apply_top(1'b0, '1, "R8 wrapper idle");
    apply_top(1'b1, '0, "R8 wrapper disabled all low");

    // Walking single low line: R6.
    for (int i = 0; i < RW; i++) begin
      apply_top(1'b0, ~(RW'(1) << i), "R6 walk");
      apply_top(1'b1, ~(RW'(1) << i), "R8 walk disabled");
    end

    // Pairs: R7 cross-stage hiding, R2 within a stage.
    for (int i = 0; i < RW; i++) begin
      for (int j = 0; j < i; j += 3) begin
        apply_top(1'b0, ~((RW'(1) << i) | (RW'(1) << j)),
                  ((i / 8) != (j / 8)) ? "R7 cross-stage pair" : "R2 R6 same-stage pair");
      end
    end

    // Random vectors of several densities.
    for (int k = 0; k < 1500; k++) begin
      logic [RW-1:0] act;
      act = RW'($urandom);
      if (k % 3 == 1) act = act & RW'($urandom);
      if (k % 3 == 2) act = act & RW'($urandom) & RW'($urandom) & RW'($urandom);
      apply_top((k % 10) == 0, ~act, "R6 R7 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule